// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, side A and side B, through a set of independent byte-wide channels. Each channel carries traffic in either direction. A live path passes the opposite bus straight through. A stored path presents the contents of a capture register. Each direction has its own capture register, its own capture strobe, its own live-or-stored select and its own output enable. The two enables have opposite polarities. Because the buses are modelled for synthesis, each side appears as an input vector, an output vector and a per-bit output-enable vector. The surrounding pad logic resolves them into a real three-state pin.

The capture strobes are ordinary signals that are sampled in the block clock domain. A capture takes place on each low-to-high change of a strobe, whatever the selects and enables are doing. When a side is being driven by the block, the value captured from that side is the driven value, not the external input. This allows one stored value to be copied into both registers. When both directions are enabled and both use the live path, each bus is held at its previous level by the block itself.

Top module: `regxcvr_top`

## Requirements
- R1: The bus is split into NUM_CH channels of CH_W bits. Channel c owns bits [c*CH_W +: CH_W] of every data vector and bit c of every control vector, and it never affects another channel.
- R2: The A-to-B enable `ab_oe` is active high and sets all CH_W bits of `b_oe` for its channel. The B-to-A enable `ba_oe_n` is active low and sets all CH_W bits of `a_oe` for its channel.
- R3: On any side whose output enable is off, the output data vector is all zeros.
- R4: A low-to-high change of `ab_stb` loads the A-side register with the resolved A bus, and a low-to-high change of `ba_stb` loads the B-side register with the resolved B bus. The load is seen one clock after the edge that samples the strobe high. The load happens regardless of selects and enables. Without such a change, the register keeps its value.
- R5: With `ab_oe`=0 and `ba_oe_n`=1 (isolation), both outputs are off, the resolved buses equal the external inputs, and the strobes still load the registers.
- R6: A select at 0 routes the opposite bus live and combinationally: `b_out` follows `a_in` in the same cycle, and `a_out` follows `b_in` in the same cycle.
- R7: A select at 1 routes that direction's register to the output, and changes on the opposite input have no effect.
- R8: With both directions enabled and both selects at 1, the A-side register drives B and the B-side register drives A at the same time.
- R9: With both directions enabled and both selects at 0, each bus holds the resolved value it had in the previous cycle, independent of the external inputs.
- R10: When the B-to-A direction drives stored data onto A, a strobe on `ab_stb` copies that stored value into the A-side register. The same holds symmetrically for the other side.
- R11: A synchronous active-low reset clears both registers of every channel and both held bus values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_stb | input | NUM_CH | Per-channel A-side register capture strobe |
| ba_stb | input | NUM_CH | Per-channel B-side register capture strobe |
| ab_sel | input | NUM_CH | Per-channel A-to-B source: 0 live, 1 stored |
| ba_sel | input | NUM_CH | Per-channel B-to-A source: 0 live, 1 stored |
| ab_oe | input | NUM_CH | Per-channel A-to-B enable, active high |
| ba_oe_n | input | NUM_CH | Per-channel B-to-A enable, active low |
| a_in | input | NUM_CH*CH_W | External level on the A bus |
| b_in | input | NUM_CH*CH_W | External level on the B bus |
| a_out | output | NUM_CH*CH_W | Data driven onto the A bus |
| a_oe | output | NUM_CH*CH_W | Per-bit drive enable for the A bus |
| b_out | output | NUM_CH*CH_W | Data driven onto the B bus |
| b_oe | output | NUM_CH*CH_W | Per-bit drive enable for the B bus |

## Verification
The hardest situation to reach from the ports is the self-holding state of R9, because the held level can only be observed once both buses are already being driven by the block. The stimulus first runs a live A-to-B transfer for a couple of cycles, so that both held values settle on the A input. It then enables B-to-A live in the same half-cycle and afterwards moves both external inputs to different values. Only a bus that holds itself still shows the earlier level. The register copy of R10 is reached in a similar way: the B-to-A stored path is enabled with a conflicting A input, the A-side strobe is pulsed, and the A-side register is then read through the stored A-to-B path.

// File: rtl/regxcvr_pkg.sv
// Package: shared types for the registered bus transceiver.
// Assumes: enable inputs have already been converted to active-high form.
package regxcvr_pkg;

    // Direction activity of one channel, decoded from its two enables.
    typedef enum logic [1:0] {
        XMODE_ISOLATE = 2'b00,
        XMODE_A2B     = 2'b01,
        XMODE_B2A     = 2'b10,
        XMODE_BOTH    = 2'b11
    } xmode_t;

    // Combine the two active-high direction enables into a mode.
    function automatic xmode_t decode_mode(input logic ab_en, input logic ba_en);
        return xmode_t'({ba_en, ab_en});
    endfunction

endpackage

// File: rtl/regxcvr_edge.sv
// Module: regxcvr_edge
// Detects a low-to-high change on a strobe that is sampled in the clk domain.
// Assumes: the strobe is synchronous to clk, or already synchronized, and each
// level lasts at least one clk cycle. After reset, the previous level is taken
// as high, so a strobe that is held high through reset produces no edge.
module regxcvr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    // Remember the strobe level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // A single-cycle detection cannot repeat on the next clock.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4

endmodule

// File: rtl/regxcvr_lane.sv
// Module: regxcvr_lane
// One channel of the transceiver. It holds the A-side and B-side capture
// registers, the previous resolved bus levels used for self-holding, and the
// live/stored source selection for each direction.
// Assumes: capture edges arrive as single-cycle pulses in the clk domain.
module regxcvr_lane
    import regxcvr_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ab_rise,
    input  logic            ba_rise,
    input  logic            ab_en,
    input  logic            ba_en,
    input  logic            ab_sel,
    input  logic            ba_sel,
    input  logic [CH_W-1:0] a_in,
    input  logic [CH_W-1:0] b_in,
    output logic [CH_W-1:0] a_out,
    output logic [CH_W-1:0] a_oe,
    output logic [CH_W-1:0] b_out,
    output logic [CH_W-1:0] b_oe
);

    localparam logic [CH_W-1:0] ZERO = '0;

    xmode_t          mode;
    logic [CH_W-1:0] reg_a;
    logic [CH_W-1:0] reg_b;
    logic [CH_W-1:0] a_hold;
    logic [CH_W-1:0] b_hold;
    logic [CH_W-1:0] a_bus;
    logic [CH_W-1:0] b_bus;
    logic            loop_hold;

    assign mode      = decode_mode(ab_en, ba_en);
    assign loop_hold = (mode == XMODE_BOTH) && !ab_sel && !ba_sel;

    // Resolve the level on each bus from who drives it and from which source.
    always_comb begin
        a_bus = a_in;
        b_bus = b_in;
        case (mode)
            XMODE_ISOLATE: begin
                a_bus = a_in;
                b_bus = b_in;
            end
            XMODE_A2B: begin
                a_bus = a_in;
                b_bus = ab_sel ? reg_a : a_in;
            end
            XMODE_B2A: begin
                b_bus = b_in;
                a_bus = ba_sel ? reg_b : b_in;
            end
            XMODE_BOTH: begin
                if (ab_sel && ba_sel) begin
                    a_bus = reg_b;
                    b_bus = reg_a;
                end else if (ab_sel) begin
                    b_bus = reg_a;
                    a_bus = reg_a;
                end else if (ba_sel) begin
                    a_bus = reg_b;
                    b_bus = reg_b;
                end else begin
                    a_bus = a_hold;
                    b_bus = b_hold;
                end
            end
            default: begin
                a_bus = a_in;
                b_bus = b_in;
            end
        endcase
    end

    // Drive only the sides whose direction is enabled.
    always_comb begin
        a_oe  = {CH_W{ba_en}};
        b_oe  = {CH_W{ab_en}};
        a_out = ba_en ? a_bus : ZERO;
        b_out = ab_en ? b_bus : ZERO;
    end

    // Capture the resolved A bus on an A-side strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       reg_a <= ZERO;
        else if (ab_rise) reg_a <= a_bus;
    end

    // Capture the resolved B bus on a B-side strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       reg_b <= ZERO;
        else if (ba_rise) reg_b <= b_bus;
    end

    // Track the previous resolved levels that are used for self-holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold <= ZERO;
            b_hold <= ZERO;
        end else begin
            a_hold <= a_bus;
            b_hold <= b_bus;
        end
    end

    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
        ab_rise |=> reg_a == $past(a_bus)); // R4
    AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
        ba_rise |=> reg_b == $past(b_bus)); // R4
    AST_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_rise |=> $stable(reg_a)); // R4
    AST_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_rise |=> $stable(reg_b)); // R4
    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(loop_hold) && loop_hold) |->
            (a_out == $past(a_out) && b_out == $past(b_out))); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_a == ZERO && reg_b == ZERO &&
                           a_hold == ZERO && b_hold == ZERO)); // R11

endmodule

// File: rtl/regxcvr_top.sv
// Module: regxcvr_top
// Registered bidirectional bus transceiver built from NUM_CH independent
// channels of CH_W bits. The three-state buses are split into input, output
// and output-enable vectors for each side.
// Assumes: all strobes and controls are synchronous to clk.
module regxcvr_top #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CH_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ab_stb,
    input  logic [NUM_CH-1:0]        ba_stb,
    input  logic [NUM_CH-1:0]        ab_sel,
    input  logic [NUM_CH-1:0]        ba_sel,
    input  logic [NUM_CH-1:0]        ab_oe,
    input  logic [NUM_CH-1:0]        ba_oe_n,
    input  logic [NUM_CH*CH_W-1:0]   a_in,
    input  logic [NUM_CH*CH_W-1:0]   b_in,
    output logic [NUM_CH*CH_W-1:0]   a_out,
    output logic [NUM_CH*CH_W-1:0]   a_oe,
    output logic [NUM_CH*CH_W-1:0]   b_out,
    output logic [NUM_CH*CH_W-1:0]   b_oe
);

    localparam int unsigned BUS_W = NUM_CH * CH_W;

    logic [NUM_CH-1:0] ab_rise;
    logic [NUM_CH-1:0] ba_rise;
    logic [NUM_CH-1:0] ab_en;
    logic [NUM_CH-1:0] ba_en;

    // Convert both enables to active-high form.
    assign ab_en = ab_oe;
    assign ba_en = ~ba_oe_n;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        regxcvr_edge u_ab_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (ab_stb[c]),
            .rise (ab_rise[c])
        );

        regxcvr_edge u_ba_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (ba_stb[c]),
            .rise (ba_rise[c])
        );

        regxcvr_lane #(.CH_W(CH_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ab_rise(ab_rise[c]),
            .ba_rise(ba_rise[c]),
            .ab_en  (ab_en[c]),
            .ba_en  (ba_en[c]),
            .ab_sel (ab_sel[c]),
            .ba_sel (ba_sel[c]),
            .a_in   (a_in[c*CH_W +: CH_W]),
            .b_in   (b_in[c*CH_W +: CH_W]),
            .a_out  (a_out[c*CH_W +: CH_W]),
            .a_oe   (a_oe[c*CH_W +: CH_W]),
            .b_out  (b_out[c*CH_W +: CH_W]),
            .b_oe   (b_oe[c*CH_W +: CH_W])
        );

        // An isolated channel drives neither side.
        AST_ISOLATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_oe[c] && ba_oe_n[c]) |->
                (a_oe[c*CH_W +: CH_W] == '0 && b_oe[c*CH_W +: CH_W] == '0 &&
                 a_out[c*CH_W +: CH_W] == '0 && b_out[c*CH_W +: CH_W] == '0)); // R5
    end

    // A side without drive always presents zero data.
    AST_NO_DRIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0)); // R3

    initial begin
        if (BUS_W == 0) $display("regxcvr_top: zero-width bus");
    end

endmodule

// File: tb/regxcvr_top_tb_top.sv
// Directed bench for regxcvr_top: one task per scenario, each checking itself.
module regxcvr_top_tb_top;

    localparam int NUM_CH = 2;
    localparam int CH_W   = 8;
    localparam int W      = NUM_CH * CH_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] ab_stb = '0, ba_stb = '0, ab_sel = '0, ba_sel = '0;
    logic [NUM_CH-1:0] ab_oe = '0, ba_oe_n = '1;
    logic [W-1:0]      a_in = '0, b_in = '0;
    logic [W-1:0]      a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    regxcvr_top #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ab_stb(ab_stb), .ba_stb(ba_stb),
        .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply controls at a falling edge and let combinational outputs settle.
    task automatic set_ctl(input logic [1:0] aoe, input logic [1:0] boen,
                           input logic [1:0] asel, input logic [1:0] bsel);
        @(negedge clk);
        ab_oe = aoe; ba_oe_n = boen; ab_sel = asel; ba_sel = bsel;
        #1;
    endtask

    task automatic pulse(input logic [1:0] am, input logic [1:0] bm);
        @(negedge clk);
        ab_stb = am; ba_stb = bm;
        @(negedge clk);
        ab_stb = '0; ba_stb = '0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 R11 a_oe in reset", a_oe, '0);
        chk("R3 R11 b_out in reset", b_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        set_ctl(2'b11, 2'b00, 2'b11, 2'b11);
        chk("R11 A-side register cleared", b_out, '0);
        chk("R11 B-side register cleared", a_out, '0);
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
    endtask

    task automatic t_polarity;
        set_ctl(2'b11, 2'b11, 2'b00, 2'b00);
        chk("R2 ab_oe high drives B", b_oe, 16'hffff);
        chk("R2 ba_oe_n high leaves A", a_oe, 16'h0000);
        set_ctl(2'b00, 2'b00, 2'b00, 2'b00);
        chk("R2 ba_oe_n low drives A", a_oe, 16'hffff);
        chk("R2 ab_oe low leaves B", b_oe, 16'h0000);
        set_ctl(2'b01, 2'b01, 2'b00, 2'b00);
        chk("R1 R2 per-channel b_oe", b_oe, 16'h00ff);
        chk("R1 R2 per-channel a_oe", a_oe, 16'hff00);
    endtask

    task automatic t_isolate_store;
        set_ctl(2'b00, 2'b11, 2'b11, 2'b11);
        a_in = 16'h1234; b_in = 16'habcd; #1;
        chk("R5 isolated a_out", a_out, '0);
        chk("R5 isolated b_out", b_out, '0);
        pulse(2'b11, 2'b11);
        a_in = 16'h5555; b_in = 16'h6666;
        repeat (3) @(negedge clk);
        set_ctl(2'b11, 2'b00, 2'b11, 2'b11);
        chk("R4 R5 R8 A-side register to B", b_out, 16'h1234);
        chk("R4 R5 R8 B-side register to A", a_out, 16'habcd);
    endtask

    task automatic t_live;
        set_ctl(2'b11, 2'b11, 2'b00, 2'b00);
        a_in = 16'h0f0f; #1;
        chk("R6 live A to B", b_out, 16'h0f0f);
        a_in = 16'hf0f0; #1;
        chk("R6 live A to B follows", b_out, 16'hf0f0);
        set_ctl(2'b00, 2'b00, 2'b00, 2'b00);
        b_in = 16'h3c3c; #1;
        chk("R6 live B to A", a_out, 16'h3c3c);
    endtask

    task automatic t_stored;
        set_ctl(2'b11, 2'b11, 2'b11, 2'b00);
        a_in = 16'h9999; #1;
        chk("R7 stored A to B ignores a_in", b_out, 16'h1234);
        set_ctl(2'b00, 2'b00, 2'b00, 2'b11);
        b_in = 16'h7777; #1;
        chk("R7 stored B to A ignores b_in", a_out, 16'habcd);
    endtask

    task automatic t_loop_hold;
        set_ctl(2'b11, 2'b11, 2'b00, 2'b00);
        a_in = 16'h7e7e; b_in = 16'h0000;
        repeat (2) @(negedge clk);
        set_ctl(2'b11, 2'b00, 2'b00, 2'b00);
        chk("R9 A holds on entry", a_out, 16'h7e7e);
        chk("R9 B holds on entry", b_out, 16'h7e7e);
        a_in = 16'h0000; b_in = 16'hffff;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 A still held", a_out, 16'h7e7e);
        chk("R9 B still held", b_out, 16'h7e7e);
    endtask

    task automatic t_store_both;
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
        a_in = 16'h1111; b_in = 16'h2222;
        pulse(2'b11, 2'b11);
        set_ctl(2'b00, 2'b00, 2'b00, 2'b11);
        a_in = 16'h9999; #1;
        chk("R10 stored B on A", a_out, 16'h2222);
        pulse(2'b11, 2'b00);
        set_ctl(2'b11, 2'b11, 2'b11, 2'b00);
        chk("R10 B value copied into A-side register", b_out, 16'h2222);
    endtask

    task automatic t_independent;
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
        a_in = 16'haa55;
        pulse(2'b01, 2'b00);
        set_ctl(2'b11, 2'b11, 2'b11, 2'b00);
        chk("R1 only channel 0 captured", b_out, 16'h2255);
        set_ctl(2'b11, 2'b11, 2'b01, 2'b00);
        a_in = 16'hc3aa; #1;
        chk("R1 channel 1 live, channel 0 stored", b_out, 16'hc355);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_polarity();
        t_isolate_store();
        t_live();
        t_stored();
        t_loop_hold();
        t_store_both();
        t_independent();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule